// File: doc/BRIEF.md
# Write-Protected PLL Reference Divider

This block holds the byte-wide control word that sets up the reference clock of a PLL, and derives that reference from one of two sources. With the crystal oscillator enabled, a programmable down-counter divides the oscillator enable stream by a ratio from 1 to 16. With the oscillator disabled, an internal 1 MHz enable stream passes straight through and the divider is bypassed. The reference leaves the block as a single-cycle enable pulse in the core clock domain.

Software can read the control word at any time. A write changes the word only while the protection flag is clear and the PLL-select flag is set. Each accepted write raises two single-cycle pulses that clear the PLL lock flag and the oscillator-ready flag, because the new setting invalidates both. The block also reports the PLL loop-filter range code in effect. That code is the programmed range while the oscillator runs and a fixed code while the internal clock is the reference.

Top module: `pll_ref_divider`

## Requirements
- R1: After reset the control word reads 0x0F (range field 00, divider field 1111). `refTick`, `clrLock` and `clrOscReady` are low.
- R2: `busRdata` always shows the current control word `{range[1:0], 2'b00, div[3:0]}`, with range in bits 7:6 and div in bits 3:0. No select or read strobe is needed.
- R3: A write (`busSel` and `busWr` high at a clock edge) updates the word from `busWdata` only when `protOn` is 0 and `pllSelect` is 1. Any other write leaves the word unchanged.
- R4: Bits 5:4 of the word ignore written data and always read as zero.
- R5: `clrLock` and `clrOscReady` are high in exactly the cycles in which an accepted write is presented, combinationally with it, and low otherwise.
- R6: With `oscEnable` high, the divider counts `oscTick` pulses and emits one `refTick` per div+1 of them. `refTick` is high in the cycle after the `oscTick` that completes a period. After reset the first period lasts 16 ticks.
- R7: A change to the divider field does not cut the period in progress short. The new value is loaded when the current count reaches zero.
- R8: With `oscEnable` low, `refTick` equals `intTick` delayed by one cycle. While the oscillator is disabled the counter is reloaded from the divider field, so a later enable starts a full period.
- R9: `filterRange` equals the range field while `oscEnable` is high and is forced to 2'b01 (the 1–2 MHz code) while it is low. Writes to the range field are still accepted in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register selected by the bus |
| busWr | input | 1 | Write strobe, qualified by busSel |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Current control word |
| protOn | input | 1 | Write protection active |
| pllSelect | input | 1 | PLL-select flag; writes need it set |
| oscEnable | input | 1 | External oscillator enabled |
| oscTick | input | 1 | One pulse per oscillator clock period |
| intTick | input | 1 | One pulse per internal 1 MHz clock period |
| refTick | output | 1 | Reference clock enable pulse |
| filterRange | output | 2 | Loop-filter range code in effect |
| clrLock | output | 1 | Pulse that clears the lock status |
| clrOscReady | output | 1 | Pulse that clears the oscillator-ready status |

## Verification
The hardest case to reach is a divider rewrite that lands partway through a period. If that write loaded the counter at once, the output would show a short reference period. The stimulus sets a large ratio, lets a few oscillator ticks elapse, writes a small ratio and keeps ticking. The model then expects the old period to finish before the new one starts. Random phases of tick streams, blocked writes and oscillator toggles are mixed over several thousand cycles, with every output compared against the behavioural model on each clock.

// File: rtl/pll_ref_pkg.sv
package pll_ref_pkg;

  // Strobes handed from control to datapath once per cycle
  typedef struct packed {
    logic wrTake;     // accepted write, load the control word
    logic cntRun;     // oscillator tick while the oscillator is enabled
    logic cntBypass;  // oscillator disabled: pass internal clock through
  } refStrobes_t;

endpackage

// File: rtl/pll_ref_ctrl.sv
module pll_ref_ctrl
  import pll_ref_pkg::*;
(
  input  logic        busSel,
  input  logic        busWr,
  input  logic        protOn,
  input  logic        pllSelect,
  input  logic        oscEnable,
  input  logic        oscTick,
  output refStrobes_t strobes,
  output logic        clrLock,
  output logic        clrOscReady
);

  logic writeSeen;
  logic writeAllowed;

  assign writeSeen    = busSel & busWr;
  assign writeAllowed = ~protOn & pllSelect;

  always_comb begin
    strobes           = '0;
    strobes.wrTake    = writeSeen & writeAllowed;
    strobes.cntBypass = ~oscEnable;
    strobes.cntRun    = oscEnable & oscTick;
  end

  // New settings invalidate lock and oscillator-ready status
  assign clrLock     = strobes.wrTake;
  assign clrOscReady = strobes.wrTake;

endmodule

// File: rtl/pll_ref_datapath.sv
module pll_ref_datapath
  import pll_ref_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RANGE_W    = 2,
  parameter int unsigned DIV_W      = 4,
  parameter logic [RANGE_W-1:0] RESET_RANGE = '0,
  parameter logic [DIV_W-1:0]   RESET_DIV   = '1,
  parameter logic [RANGE_W-1:0] FIXED_RANGE = 2'b01
) (
  input  logic               clk,
  input  logic               rstN,
  input  refStrobes_t        strobes,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               oscEnable,
  input  logic               intTick,
  output logic [DATA_W-1:0]  busRdata,
  output logic               refTick,
  output logic [RANGE_W-1:0] filterRange
);

  localparam int unsigned PAD_W = DATA_W - RANGE_W - DIV_W;
  localparam int unsigned RANGE_LSB = DATA_W - RANGE_W;

  logic [RANGE_W-1:0] rangeQ;
  logic [DIV_W-1:0]   divQ;
  logic [DIV_W-1:0]   cntQ;
  logic               refQ;
  logic               cntAtZero;

  // Control word: only range and divider are stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeQ <= RESET_RANGE;
      divQ   <= RESET_DIV;
    end else if (strobes.wrTake) begin
      rangeQ <= busWdata[RANGE_LSB +: RANGE_W];
      divQ   <= busWdata[DIV_W-1:0];
    end
  end

  assign cntAtZero = (cntQ == '0);

  // Down-counter reloads from the stored divider only at wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= RESET_DIV;
      refQ <= 1'b0;
    end else if (strobes.cntBypass) begin
      cntQ <= divQ;
      refQ <= intTick;
    end else if (strobes.cntRun) begin
      if (cntAtZero) begin
        cntQ <= divQ;
        refQ <= 1'b1;
      end else begin
        cntQ <= cntQ - DIV_W'(1);
        refQ <= 1'b0;
      end
    end else begin
      refQ <= 1'b0;
    end
  end

  assign refTick = refQ;

  generate
    if (PAD_W > 0) begin : g_pad
      assign busRdata = {rangeQ, {PAD_W{1'b0}}, divQ};
    end else begin : g_nopad
      assign busRdata = {rangeQ, divQ};
    end
  endgenerate

  assign filterRange = oscEnable ? rangeQ : FIXED_RANGE;

endmodule

// File: rtl/pll_ref_divider.sv
module pll_ref_divider
  import pll_ref_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RANGE_W = 2,
  parameter int unsigned DIV_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               protOn,
  input  logic               pllSelect,
  input  logic               oscEnable,
  input  logic               oscTick,
  input  logic               intTick,
  output logic               refTick,
  output logic [RANGE_W-1:0] filterRange,
  output logic               clrLock,
  output logic               clrOscReady
);

  refStrobes_t strobes;

  pll_ref_ctrl u_ctrl (
    .busSel      (busSel),
    .busWr       (busWr),
    .protOn      (protOn),
    .pllSelect   (pllSelect),
    .oscEnable   (oscEnable),
    .oscTick     (oscTick),
    .strobes     (strobes),
    .clrLock     (clrLock),
    .clrOscReady (clrOscReady)
  );

  pll_ref_datapath #(
    .DATA_W  (DATA_W),
    .RANGE_W (RANGE_W),
    .DIV_W   (DIV_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .busWdata    (busWdata),
    .oscEnable   (oscEnable),
    .intTick     (intTick),
    .busRdata    (busRdata),
    .refTick     (refTick),
    .filterRange (filterRange)
  );

endmodule

// File: rtl/pll_ref_divider_checker.sv
module pll_ref_divider_checker #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RANGE_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWr,
  input logic [DATA_W-1:0]  busRdata,
  input logic               protOn,
  input logic               pllSelect,
  input logic               oscEnable,
  input logic               oscTick,
  input logic               intTick,
  input logic               refTick,
  input logic [RANGE_W-1:0] filterRange,
  input logic               clrLock,
  input logic               clrOscReady
);

  // R3: a blocked or absent write leaves the word unchanged
  a_r3_blocked_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr && !protOn && pllSelect) |=> $stable(busRdata));

  // R4: padding bits read zero
  a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[5:4] == 2'b00);

  // R5: both clear pulses agree and only fire on a presented write
  a_r5_pulse_pair: assert property (@(posedge clk) disable iff (!rstN)
    clrLock == clrOscReady);
  a_r5_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    clrLock |-> (busSel && busWr && pllSelect && !protOn));

  // R6: no reference pulse without a preceding oscillator tick
  a_r6_tick_needed: assert property (@(posedge clk) disable iff (!rstN)
    (oscEnable && !oscTick) |=> !refTick);

  // R8: internal clock passes through delayed one cycle
  a_r8_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !oscEnable |=> (refTick == $past(intTick)));

  // R9: forced filter code while oscillator disabled
  a_r9_forced_range: assert property (@(posedge clk) disable iff (!rstN)
    !oscEnable |-> (filterRange == 2'b01));

endmodule

bind pll_ref_divider pll_ref_divider_checker #(
  .DATA_W  (DATA_W),
  .RANGE_W (RANGE_W)
) u_chk (.*);

// File: tb/pll_ref_divider_bench.sv
`timescale 1ns/1ps
module pll_ref_divider_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       protOn = 1'b0, pllSelect = 1'b1, oscEnable = 1'b1;
  logic       oscTick = 1'b0, intTick = 1'b0;
  logic       refTick;
  logic [1:0] filterRange;
  logic       clrLock, clrOscReady;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  int mRange = 0, mDiv = 15, mCnt = 15, mRef = 0;

  always #4 clk = ~clk;  // 125 MHz

  pll_ref_divider u_pll_ref_divider (.*);

  function automatic bit accepted();
    return busSel && busWr && !protOn && pllSelect;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    int expRd = (mRange << 6) | mDiv;
    check("R2 R3 R4 readback", busRdata, expRd);
    check("R6 R7 R8 refTick", refTick, mRef);
    check("R9 filterRange", filterRange, oscEnable ? mRange : 1);
    check("R5 clrLock", clrLock, accepted());
    check("R5 clrOscReady", clrOscReady, accepted());
  endtask

  task automatic modelUpdate(bit acc, bit osc, bit otk, bit itk, int wd);
    if (!osc) begin
      mRef = itk; mCnt = mDiv;
    end else if (otk) begin
      if (mCnt == 0) begin mRef = 1; mCnt = mDiv; end
      else begin mRef = 0; mCnt = mCnt - 1; end
    end else mRef = 0;
    if (acc) begin mRange = (wd >> 6) & 3; mDiv = wd & 15; end
  endtask

  // called at a negative edge with inputs set
  task automatic cycle();
    bit acc = accepted();
    bit osc = oscEnable, otk = oscTick, itk = intTick;
    int wd = busWdata;
    #1 compareAll();
    @(posedge clk);
    modelUpdate(acc, osc, otk, itk, wd);
    @(negedge clk);
  endtask

  task automatic doWrite(logic [7:0] d);
    busSel = 1; busWr = 1; busWdata = d;
    cycle();
    busSel = 0; busWr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    check("R1 reset word", busRdata, 8'h0F);
    check("R1 reset refTick", refTick, 0);
    check("R1 reset clrLock", clrLock, 0);
    check("R1 reset clrOscReady", clrOscReady, 0);
    @(negedge clk);
    rstN = 1;

    // R6: first period after reset is 16 ticks
    oscTick = 1;
    repeat (20) cycle();
    oscTick = 0;

    // R3: protection blocks write, missing PLL-select blocks write
    protOn = 1; doWrite(8'h45); cycle();
    protOn = 0; pllSelect = 0; doWrite(8'h45); cycle();
    pllSelect = 1;
    // R4 R5: accepted write with pad bits set
    doWrite(8'hFF); cycle();
    // R6: ratio 1, tick every cycle
    doWrite(8'h40); oscTick = 1; repeat (6) cycle();
    // R6: ratio 4, tick every other cycle
    doWrite(8'h83);
    for (int i = 0; i < 24; i++) begin oscTick = i[0]; cycle(); end
    // R7: change divider mid-period
    oscTick = 1; doWrite(8'h0B); repeat (13) cycle();
    repeat (4) cycle();
    doWrite(8'h01); repeat (20) cycle();
    // R8 R9: oscillator disabled, internal clock passes through
    oscEnable = 0;
    for (int i = 0; i < 20; i++) begin intTick = (i % 3 == 0); cycle(); end
    doWrite(8'hC2); cycle();
    oscEnable = 1; oscTick = 1; repeat (8) cycle();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      oscTick   = ($urandom_range(0, 2) != 0);
      intTick   = ($urandom_range(0, 4) == 0);
      protOn    = ($urandom_range(0, 5) == 0);
      pllSelect = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 60) == 0) oscEnable = ~oscEnable;
      busSel    = ($urandom_range(0, 12) == 0);
      busWr     = ($urandom_range(0, 1) == 1);
      busWdata  = 8'($urandom);
      cycle();
    end
    busSel = 0; busWr = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule